// File: doc/BRIEF.md
# Current-Mode PWM Cycle Timer

This block is the digital timing core of a peak-current-mode flyback controller. A free-running counter on the system clock marks out switching periods. Each period opens with the gate request raised and a one-clock `cycle_start` strobe, which protection counters elsewhere use to count switching cycles. The on-time ends at whichever comes first: a current-limit trip, a feedback trip, or a hard duty clamp at three quarters of the period.

The two trip flags come from comparators that are already digitised. Both are masked for a programmable number of clocks after each turn-on, so that the turn-on current spike cannot end the pulse early. The period for the next cycle is chosen at each cycle boundary. It is either the programmed normal period or, while the light-load flag is high, a longer green period. An off request or a low enable stops switching at once and holds the counter idle. Analog sensing, slope compensation and the gate driver sit outside this block.

Top module: `pwm_cycle_timer`

## Requirements
- R1: While `enable` is high and `off_req` is low, each switching period of P clocks begins with `gate` high and with `cycle_start` high for exactly one clock. Consecutive `cycle_start` pulses are P clocks apart.
- R2: `cs_trip` or `fb_trip`, either one alone, that is high at a rising edge after blanking has expired drives `gate` low at that edge. `gate` then stays low for the rest of the period.
- R3: With blanking count B, trips at the first B rising edges after the cycle start edge are ignored. A trip at the edge that starts a cycle is always ignored. With both trips held high from the start, `gate` is high for B+1 clocks (or fewer if R4 clamps sooner).
- R4: `gate` is never high for more than P − floor(P/4) clocks in a period of P clocks. It falls at that count even without a trip.
- R5: The period of a cycle is `green_period_cfg` if `green_req` is high at the edge that starts the cycle, and `period_cfg` otherwise. Both are in clock cycles and must be at least 4.
- R6: Changing `green_req`, `period_cfg` or `green_period_cfg` in the middle of a cycle does not change the length of that cycle. The change applies from the next cycle start.
- R7: At the first rising edge that samples `off_req` high, `gate` goes low. `gate` and `cycle_start` stay low while `off_req` is high. At the first edge after `off_req` falls, a new cycle starts.
- R8: While `enable` is low, `gate` and `cycle_start` stay low and the counter is held idle. At the first edge with `enable` high again, a new cycle starts.
- R9: While `rst_n` is low, `gate` and `cycle_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low holds the timer idle |
| off_req | input | 1 | Off request; high stops switching at once |
| cs_trip | input | 1 | Current-limit comparator flag |
| fb_trip | input | 1 | Feedback comparator flag |
| green_req | input | 1 | Light-load flag; selects the green period |
| period_cfg | input | CNT_W | Normal period in clocks |
| green_period_cfg | input | CNT_W | Light-load period in clocks |
| blank_cfg | input | BLK_W | Blanking length in clocks after turn-on |
| gate | output | 1 | Registered gate request |
| cycle_start | output | 1 | One-clock strobe at each period start |

## Verification
The on-time and the period are measured one cycle at a time under several stimulus patterns:
- No trip at all, which exposes the duty clamp and the selected period.
- Each trip input alone, which separates the two arms of the OR.
- A trip present from the start edge with various blanking lengths, which shows exactly where masking ends.
- A trip arriving after the clamp point, which shows that the clamp wins.

Mid-cycle changes of the green flag tell a boundary-aligned period switch apart from an immediate one. Off request and enable drops are applied while the gate is high, to show that the gate falls on the next edge and that a fresh cycle starts right after release.

// File: rtl/pct_pkg.sv
package pct_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ON   = 2'd1,
        PH_OFF  = 2'd2
    } phase_e;

    localparam int DUTY_SHIFT = 2;
endpackage

// File: rtl/pct_period_sel.sv
module pct_period_sel #(
    parameter int CNT_W = 16
) (
    input  logic             green_req,
    input  logic [CNT_W-1:0] period_cfg,
    input  logic [CNT_W-1:0] green_period_cfg,
    output logic [CNT_W-1:0] nxt_per,
    output logic [CNT_W-1:0] nxt_lim
);
    import pct_pkg::*;

    always_comb begin
        nxt_per = green_req ? green_period_cfg : period_cfg;
        nxt_lim = nxt_per - (nxt_per >> DUTY_SHIFT);
    end

    always_comb begin
        assert_lim_below_per_R4: assert (nxt_per < 4 || nxt_lim < nxt_per);
    end
endmodule

// File: rtl/pct_blank_timer.sv
module pct_blank_timer #(
    parameter int BLK_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BLK_W-1:0] blank_cfg,
    input  logic             cs_trip,
    input  logic             fb_trip,
    output logic             trip_ok
);
    logic [BLK_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = blank_cfg;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign trip_ok = (cs_trip || fb_trip) && (cnt_q == '0);

    assert_blank_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(blank_cfg)));
endmodule

// File: rtl/pwm_cycle_timer.sv
module pwm_cycle_timer #(
    parameter int CNT_W = 16,
    parameter int BLK_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             off_req,
    input  logic             cs_trip,
    input  logic             fb_trip,
    input  logic             green_req,
    input  logic [CNT_W-1:0] period_cfg,
    input  logic [CNT_W-1:0] green_period_cfg,
    input  logic [BLK_W-1:0] blank_cfg,
    output logic             gate,
    output logic             cycle_start
);
    import pct_pkg::*;

    typedef struct packed {
        phase_e           phase;
        logic             gate;
        logic             start;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] lim;
    } st_t;

    st_t s_d, s_q;

    logic [CNT_W-1:0] nxt_per, nxt_lim, cnt_inc;
    logic             run_ok, begin_c, trip_ok;

    pct_period_sel #(.CNT_W(CNT_W)) u_sel (
        .green_req        (green_req),
        .period_cfg       (period_cfg),
        .green_period_cfg (green_period_cfg),
        .nxt_per          (nxt_per),
        .nxt_lim          (nxt_lim)
    );

    pct_blank_timer #(.BLK_W(BLK_W)) u_blank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (begin_c),
        .blank_cfg (blank_cfg),
        .cs_trip   (cs_trip),
        .fb_trip   (fb_trip),
        .trip_ok   (trip_ok)
    );

    always_comb begin
        run_ok  = enable && !off_req;
        cnt_inc = s_q.cnt + 1'b1;
        begin_c = run_ok && ((s_q.phase == PH_IDLE) || (cnt_inc == s_q.per));
    end

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        if (!run_ok) begin
            s_d.phase = PH_IDLE;
            s_d.gate  = 1'b0;
            s_d.cnt   = '0;
        end else if (begin_c) begin
            s_d.phase = PH_ON;
            s_d.gate  = 1'b1;
            s_d.start = 1'b1;
            s_d.cnt   = '0;
            s_d.per   = nxt_per;
            s_d.lim   = nxt_lim;
        end else begin
            s_d.cnt = cnt_inc;
            if (s_q.phase == PH_ON && (trip_ok || cnt_inc >= s_q.lim)) begin
                s_d.phase = PH_OFF;
                s_d.gate  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, gate: 1'b0, start: 1'b0,
                     cnt: '0, per: '0, lim: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign gate        = s_q.gate;
    assign cycle_start = s_q.start;

    // R1: a cycle opens with the gate up, and the strobe lasts one clock
    assert_gate_at_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> gate);
    assert_start_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> !cycle_start);
    // R4: the gate is never up at or beyond the clamp count
    assert_duty_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (s_q.cnt < s_q.lim));
    // R6: the active period holds for the whole cycle
    assert_period_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE && !cycle_start && $past(s_q.phase != PH_IDLE))
            |-> (s_q.per == $past(s_q.per)));
    // R7: an off request stops the gate at the next edge
    assert_off_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        off_req |=> (!gate && !cycle_start));
    // R8: a low enable stops the gate at the next edge
    assert_enable_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!gate && !cycle_start));
endmodule

// File: tb/sim_pwm_cycle_timer.sv
module sim_pwm_cycle_timer;
    localparam int CLK_NS = 10;
    localparam int NV     = 10;

    typedef struct packed {
        int per; int gper; int blk; int grn; int cs; int fb; int t; int on; int cyc;
    } vec_t;

    // t: cycle index from which the trip level is driven (99 = never)
    localparam vec_t VEC [NV] = '{
        '{20, 60,  3, 0, 0, 0, 99, 15, 20},   // R4 clamp, normal period
        '{20, 60,  3, 1, 0, 0, 99, 45, 60},   // R5 green period
        '{20, 60,  3, 0, 1, 0,  6,  7, 20},   // R2 current trip alone
        '{20, 60,  3, 0, 0, 1,  6,  7, 20},   // R2 feedback trip alone
        '{20, 60,  5, 0, 1, 0,  0,  6, 20},   // R3 masked by blanking
        '{20, 60,  0, 0, 0, 1,  0,  1, 20},   // R3 zero blanking
        '{20, 60,  3, 0, 1, 1, 16, 15, 20},   // R4 clamp wins over late trip
        '{33, 60,  2, 0, 0, 0, 99, 25, 33},   // R4 odd period
        '{ 8, 60,  0, 0, 0, 0, 99,  6,  8},   // R1 short period
        '{20, 60, 20, 0, 1, 0,  0, 15, 20}    // R3 blanking longer than clamp
    };

    logic        clk = 1'b0;
    logic        rst_n, enable, off_req, cs_trip, fb_trip, green_req;
    logic [15:0] period_cfg, green_period_cfg;
    logic [5:0]  blank_cfg;
    logic        gate, cycle_start;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    pwm_cycle_timer u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .off_req(off_req),
        .cs_trip(cs_trip), .fb_trip(fb_trip), .green_req(green_req),
        .period_cfg(period_cfg), .green_period_cfg(green_period_cfg),
        .blank_cfg(blank_cfg), .gate(gate), .cycle_start(cycle_start)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_start();
        int g = 0;
        @(negedge clk);
        while (!cycle_start && g < 1000) begin
            @(negedge clk);
            g++;
        end
    endtask

    // called at the negedge where cycle_start is seen high
    task automatic measure(input int t, input bit cs, input bit fb,
                           output int on, output int cyc);
        int k = 0;
        on = 0;
        do begin
            if (k == t) begin cs_trip = cs; fb_trip = fb; end
            if (gate) on++;
            @(negedge clk);
            k++;
        end while (!cycle_start && k < 1000);
        cs_trip = 1'b0;
        fb_trip = 1'b0;
        cyc = k;
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int on, cyc, bad, k;
        rst_n = 1'b0; enable = 1'b1; off_req = 1'b0;
        cs_trip = 1'b0; fb_trip = 1'b0; green_req = 1'b0;
        period_cfg = 16'd20; green_period_cfg = 16'd60; blank_cfg = 6'd3;

        repeat (3) @(negedge clk);
        chk("R9 gate in reset", int'(gate), 0);
        chk("R9 cycle_start in reset", int'(cycle_start), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            period_cfg       = VEC[i].per[15:0];
            green_period_cfg = VEC[i].gper[15:0];
            blank_cfg        = VEC[i].blk[5:0];
            green_req        = VEC[i].grn[0];
            wait_start();
            measure(VEC[i].t, VEC[i].cs[0], VEC[i].fb[0], on, cyc);
            chk($sformatf("R2/R3/R4 on-time vector %0d", i), on, VEC[i].on);
            chk($sformatf("R1/R5 period vector %0d", i), cyc, VEC[i].cyc);
        end

        // R6: green flag raised mid-cycle
        period_cfg = 16'd20; green_period_cfg = 16'd60; blank_cfg = 6'd3;
        green_req = 1'b0;
        wait_start();
        k = 0;
        do begin
            if (k == 5) green_req = 1'b1;
            @(negedge clk);
            k++;
        end while (!cycle_start && k < 1000);
        chk("R6 current cycle length kept", k, 20);
        measure(99, 1'b0, 1'b0, on, cyc);
        chk("R6 next cycle uses green period", cyc, 60);
        chk("R5 green on-time clamp", on, 45);
        green_req = 1'b0;

        // R7: off request during on-time
        wait_start();
        @(negedge clk);
        chk("R7 gate high before off", int'(gate), 1);
        off_req = 1'b1;
        @(negedge clk);
        chk("R7 gate low at next edge", int'(gate), 0);
        bad = 0;
        repeat (30) begin
            @(negedge clk);
            if (gate || cycle_start) bad++;
        end
        chk("R7 held off", bad, 0);
        off_req = 1'b0;
        @(negedge clk);
        chk("R7 restart strobe", int'(cycle_start), 1);
        chk("R7 restart gate", int'(gate), 1);

        // R8: enable dropped during on-time
        wait_start();
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R8 gate low at next edge", int'(gate), 0);
        bad = 0;
        repeat (30) begin
            @(negedge clk);
            if (gate || cycle_start) bad++;
        end
        chk("R8 held idle", bad, 0);
        enable = 1'b1;
        @(negedge clk);
        chk("R8 restart strobe", int'(cycle_start), 1);
        measure(99, 1'b0, 1'b0, on, cyc);
        chk("R8 full cycle after restart", cyc, 20);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule